// File: doc/BRIEF.md
# Line-Grouped Reorder Buffer

This block tracks in-flight macro-ops in program order, grouped into lines of three lanes. Each cycle the decode stage may hand over up to three macro-ops as a lane mask plus a tag per lane. They all go into the single line at the tail, and the block returns that line's index so later completion reports can name the line and the lane. Execution units report completion per lane, in any order. Completed results stay speculative until their whole line leaves the buffer.

Retirement works on whole lines. The oldest occupied line retires when every valid lane in it has completed. Lanes left unused at allocation count as completed from the start. At most one line retires per cycle, and allocation and retirement may happen in the same cycle. A flush empties the buffer and returns both pointers to line zero. Operand values, renaming and exceptions are handled elsewhere.

Top module: `grouped_rob`

## Requirements
- R1: After reset the buffer is empty: alloc_ready_o = 1, alloc_line_o = 0, retire_line_o = 0, retire_valid_o = 0.
- R2: When alloc_mask_i is nonzero and alloc_ready_o = 1, one line is filled at index alloc_line_o. On the next cycle alloc_line_o has advanced by one, wrapping from NUM_LINES-1 (23) to 0.
- R3: When all NUM_LINES (24) lines are occupied, alloc_ready_o = 0 and an allocate request has no effect on alloc_line_o or on the stored lines.
- R4: A line raises retire_valid_o only after every lane set in its allocation mask has completed. Lanes clear in the mask need no completion.
- R5: Only the oldest line (retire_line_o) may retire. A younger line whose lanes are all complete waits behind an incomplete older line.
- R6: retire_valid_o rises in the cycle after the clock edge that records the last missing completion. The line leaves the buffer on the next edge, after which retire_line_o has advanced by one (wrapping 23 to 0). At most one line retires per edge.
- R7: While retire_valid_o = 1, retire_mask_o gives that line's allocation mask. retire_tag_o gives its tags, with lane k in bits [k*TAG_W +: TAG_W].
- R8: A completion that names an unoccupied line has no effect.
- R9: Allocation and retirement in the same cycle both take effect.
- R10: An allocate request with alloc_mask_i = 0 has no effect.
- R11: flush_i = 1 at an edge empties every line and sets head and tail to 0. Allocate and completion requests in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empty the buffer |
| alloc_mask_i | input | LANES (3) | Valid lanes of the line being allocated |
| alloc_tag_i | input | LANES*TAG_W (24) | Per-lane macro-op tags |
| alloc_ready_o | output | 1 | A free line exists |
| alloc_line_o | output | IDX_W (5) | Index given to the next allocation |
| cmpl_valid_i | input | 1 | Completion report strobe |
| cmpl_line_i | input | IDX_W (5) | Line of the completed entry |
| cmpl_lane_i | input | LANE_W (2) | Lane of the completed entry |
| retire_valid_o | output | 1 | Head line retires at the coming edge |
| retire_line_o | output | IDX_W (5) | Index of the oldest line |
| retire_mask_o | output | LANES (3) | Valid lanes of the retiring line |
| retire_tag_o | output | LANES*TAG_W (24) | Tags of the retiring line |

## Verification
Every output depends only on registered state, so an allocation, completion or flush applied before an edge shows up one cycle later. A retirement is therefore announced one cycle after its last completion and takes effect on the edge after that. The bench drives inputs at the falling edge and checks outputs at that same point, before the next rising edge. Each row of its table therefore holds the values due from the edges already taken. The directed runs count cycles in the same way when they fill the buffer to its limit, complete lines in reverse to hold the head back, and drain a 23-line burst one line per cycle.

// File: rtl/grob_pkg.sv
package grob_pkg;
  localparam int unsigned DEF_LINES = 24;
  localparam int unsigned DEF_LANES = 3;
  localparam int unsigned DEF_TAG_W = 8;

  function automatic int unsigned wrap_inc(int unsigned ptr, int unsigned limit);
    return (ptr == limit - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/grob_ptrs.sv
module grob_ptrs #(
  parameter int unsigned NUM_LINES = grob_pkg::DEF_LINES,
  localparam int unsigned IDX_W = $clog2(NUM_LINES),
  localparam int unsigned CNT_W = $clog2(NUM_LINES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o  <= '0;
      tail_o  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      head_o  <= '0;
      tail_o  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_o <= IDX_W'(grob_pkg::wrap_inc(int'(tail_o), NUM_LINES));
      if (pop_i)  head_o <= IDX_W'(grob_pkg::wrap_inc(int'(head_o), NUM_LINES));
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign full_o = (count_q == CNT_W'(NUM_LINES));
endmodule

// File: rtl/grob_lines.sv
module grob_lines #(
  parameter int unsigned NUM_LINES = grob_pkg::DEF_LINES,
  parameter int unsigned LANES     = grob_pkg::DEF_LANES,
  parameter int unsigned TAG_W     = grob_pkg::DEF_TAG_W,
  localparam int unsigned IDX_W  = $clog2(NUM_LINES),
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  flush_i,
  input  logic                                  wr_en_i,
  input  logic [IDX_W-1:0]                      wr_idx_i,
  input  logic [LANES-1:0]                      wr_mask_i,
  input  logic [LANES*TAG_W-1:0]                wr_tags_i,
  input  logic                                  clr_en_i,
  input  logic [IDX_W-1:0]                      clr_idx_i,
  input  logic                                  cmp_en_i,
  input  logic [IDX_W-1:0]                      cmp_idx_i,
  input  logic [LANE_W-1:0]                     cmp_lane_i,
  output logic [NUM_LINES-1:0]                  occ_o,
  output logic [NUM_LINES-1:0][LANES-1:0]       mask_o,
  output logic [NUM_LINES-1:0][LANES-1:0]       done_o,
  output logic [NUM_LINES-1:0][LANES*TAG_W-1:0] tags_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    logic wr_hit, clr_hit, cmp_hit;

    assign wr_hit  = wr_en_i  && (wr_idx_i  == MY_IDX);
    assign clr_hit = clr_en_i && (clr_idx_i == MY_IDX);
    assign cmp_hit = cmp_en_i && (cmp_idx_i == MY_IDX) && occ_o[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        occ_o[i]  <= 1'b0;
        mask_o[i] <= '0;
        done_o[i] <= '0;
        tags_o[i] <= '0;
      end else if (flush_i) begin
        occ_o[i]  <= 1'b0;
        mask_o[i] <= '0;
        done_o[i] <= '0;
      end else if (wr_hit) begin
        occ_o[i]  <= 1'b1;
        mask_o[i] <= wr_mask_i;
        done_o[i] <= ~wr_mask_i;  // unused lanes start complete
        tags_o[i] <= wr_tags_i;
      end else begin
        if (clr_hit) occ_o[i] <= 1'b0;
        if (cmp_hit) done_o[i][cmp_lane_i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/grob_retire.sv
module grob_retire #(
  parameter int unsigned NUM_LINES = grob_pkg::DEF_LINES,
  parameter int unsigned LANES     = grob_pkg::DEF_LANES,
  parameter int unsigned TAG_W     = grob_pkg::DEF_TAG_W,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic [IDX_W-1:0]                      head_i,
  input  logic [NUM_LINES-1:0]                  occ_i,
  input  logic [NUM_LINES-1:0][LANES-1:0]       mask_i,
  input  logic [NUM_LINES-1:0][LANES-1:0]       done_i,
  input  logic [NUM_LINES-1:0][LANES*TAG_W-1:0] tags_i,
  output logic                                  valid_o,
  output logic [LANES-1:0]                      mask_o,
  output logic [LANES*TAG_W-1:0]                tags_o
);
  always_comb begin
    valid_o = occ_i[head_i] && (&done_i[head_i]);
    mask_o  = mask_i[head_i];
    tags_o  = tags_i[head_i];
  end
endmodule

// File: rtl/grouped_rob.sv
module grouped_rob #(
  parameter int unsigned NUM_LINES = grob_pkg::DEF_LINES,
  parameter int unsigned LANES     = grob_pkg::DEF_LANES,
  parameter int unsigned TAG_W     = grob_pkg::DEF_TAG_W,
  localparam int unsigned IDX_W  = $clog2(NUM_LINES),
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic [LANES-1:0]       alloc_mask_i,
  input  logic [LANES*TAG_W-1:0] alloc_tag_i,
  output logic                   alloc_ready_o,
  output logic [IDX_W-1:0]       alloc_line_o,
  input  logic                   cmpl_valid_i,
  input  logic [IDX_W-1:0]       cmpl_line_i,
  input  logic [LANE_W-1:0]      cmpl_lane_i,
  output logic                   retire_valid_o,
  output logic [IDX_W-1:0]       retire_line_o,
  output logic [LANES-1:0]       retire_mask_o,
  output logic [LANES*TAG_W-1:0] retire_tag_o
);
  logic                                  full, push, pop, cmp_en;
  logic [IDX_W-1:0]                      head, tail;
  logic [NUM_LINES-1:0]                  occ;
  logic [NUM_LINES-1:0][LANES-1:0]       mask, done;
  logic [NUM_LINES-1:0][LANES*TAG_W-1:0] tags;

  assign push   = (|alloc_mask_i) && !full && !flush_i;
  assign pop    = retire_valid_o && !flush_i;
  assign cmp_en = cmpl_valid_i && !flush_i
               && (cmpl_line_i < IDX_W'(NUM_LINES))
               && (cmpl_lane_i < LANE_W'(LANES));

  grob_ptrs #(.NUM_LINES(NUM_LINES)) u_ptrs (
    .clk_i, .rst_ni, .flush_i,
    .push_i(push), .pop_i(pop),
    .head_o(head), .tail_o(tail), .full_o(full)
  );

  grob_lines #(.NUM_LINES(NUM_LINES), .LANES(LANES), .TAG_W(TAG_W)) u_lines (
    .clk_i, .rst_ni, .flush_i,
    .wr_en_i(push), .wr_idx_i(tail), .wr_mask_i(alloc_mask_i), .wr_tags_i(alloc_tag_i),
    .clr_en_i(pop), .clr_idx_i(head),
    .cmp_en_i(cmp_en), .cmp_idx_i(cmpl_line_i), .cmp_lane_i(cmpl_lane_i),
    .occ_o(occ), .mask_o(mask), .done_o(done), .tags_o(tags)
  );

  grob_retire #(.NUM_LINES(NUM_LINES), .LANES(LANES), .TAG_W(TAG_W)) u_retire (
    .head_i(head), .occ_i(occ), .mask_i(mask), .done_i(done), .tags_i(tags),
    .valid_o(retire_valid_o), .mask_o(retire_mask_o), .tags_o(retire_tag_o)
  );

  assign alloc_ready_o = !full;
  assign alloc_line_o  = tail;
  assign retire_line_o = head;
endmodule

// File: rtl/grob_checker.sv
module grob_checker #(
  parameter int unsigned NUM_LINES = grob_pkg::DEF_LINES,
  parameter int unsigned LANES     = grob_pkg::DEF_LANES,
  localparam int unsigned IDX_W = $clog2(NUM_LINES),
  localparam int unsigned CNT_W = $clog2(NUM_LINES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic [LANES-1:0] alloc_mask_i,
  input logic             alloc_ready_o,
  input logic [IDX_W-1:0] alloc_line_o,
  input logic             retire_valid_o,
  input logic [IDX_W-1:0] retire_line_o,
  input logic [LANES-1:0] retire_mask_o
);
  logic             fire;
  logic [CNT_W-1:0] occ_cnt;

  assign fire = (|alloc_mask_i) && alloc_ready_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          occ_cnt <= '0;
    else if (flush_i)                     occ_cnt <= '0;
    else if (fire && !retire_valid_o)     occ_cnt <= occ_cnt + 1'b1;
    else if (!fire && retire_valid_o)     occ_cnt <= occ_cnt - 1'b1;
  end

  // R3: ready tracks the number of lines held
  p_ready_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ready_o == (occ_cnt != CNT_W'(NUM_LINES)));

  // R2
  p_tail_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> alloc_line_o == (($past(alloc_line_o) == IDX_W'(NUM_LINES - 1)) ? '0
                              : $past(alloc_line_o) + 1'b1));

  // R6
  p_head_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_valid_o && !flush_i) |=> retire_line_o == (($past(retire_line_o) == IDX_W'(NUM_LINES - 1))
                                       ? '0 : $past(retire_line_o) + 1'b1));

  // R6: head holds while nothing retires
  p_head_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retire_valid_o && !flush_i) |=> $stable(retire_line_o));

  // R7
  p_retire_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_o |-> retire_mask_o != '0);

  // R11
  p_flush_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!retire_valid_o && alloc_ready_o && alloc_line_o == '0 && retire_line_o == '0));

  // R4: nothing retires from an empty buffer
  p_empty_no_retire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_cnt == '0) |-> !retire_valid_o);
endmodule

bind grouped_rob grob_checker #(.NUM_LINES(NUM_LINES), .LANES(LANES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
  .alloc_mask_i(alloc_mask_i), .alloc_ready_o(alloc_ready_o), .alloc_line_o(alloc_line_o),
  .retire_valid_o(retire_valid_o), .retire_line_o(retire_line_o), .retire_mask_o(retire_mask_o)
);

// File: tb/grouped_rob_tb.sv
module grouped_rob_tb;
  localparam int unsigned N = 24;
  localparam int unsigned L = 3;
  localparam int unsigned TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic [L-1:0]  amask = '0;
  logic [L*TW-1:0] atag = '0;
  logic          ardy;
  logic [4:0]    aline;
  logic          cv = 1'b0;
  logic [4:0]    cline = '0;
  logic [1:0]    clane = '0;
  logic          rv;
  logic [4:0]    rline;
  logic [L-1:0]  rmask;
  logic [L*TW-1:0] rtag;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  grouped_rob #(.NUM_LINES(N), .LANES(L), .TAG_W(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .alloc_mask_i(amask), .alloc_tag_i(atag), .alloc_ready_o(ardy), .alloc_line_o(aline),
    .cmpl_valid_i(cv), .cmpl_line_i(cline), .cmpl_lane_i(clane),
    .retire_valid_o(rv), .retire_line_o(rline), .retire_mask_o(rmask), .retire_tag_o(rtag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    amask = '0; cv = 1'b0; flush = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0] am;
    logic       cv;
    logic [4:0] cl;
    logic [1:0] cn;
    logic       erv;
    logic [4:0] erl;
    logic [2:0] emask;
    logic       erdy;
    logic [4:0] eal;
    logic [7:0] req;
  } vec_t;

  // expected fields are the outputs seen before this row's inputs reach an edge
  localparam vec_t VEC [13] = '{
    '{3'b111, 1'b0, 5'd0, 2'd0, 1'b0, 5'd0, 3'b000, 1'b1, 5'd0, 8'd1},  // R1 reset state
    '{3'b001, 1'b1, 5'd0, 2'd2, 1'b0, 5'd0, 3'b000, 1'b1, 5'd1, 8'd2},  // R2
    '{3'b000, 1'b1, 5'd1, 2'd0, 1'b0, 5'd0, 3'b000, 1'b1, 5'd2, 8'd2},  // R2
    '{3'b000, 1'b1, 5'd0, 2'd0, 1'b0, 5'd0, 3'b000, 1'b1, 5'd2, 8'd5},  // R5 line1 waits
    '{3'b000, 1'b1, 5'd0, 2'd1, 1'b0, 5'd0, 3'b000, 1'b1, 5'd2, 8'd4},  // R4
    '{3'b010, 1'b0, 5'd0, 2'd0, 1'b1, 5'd0, 3'b111, 1'b1, 5'd2, 8'd9},  // R9 alloc+retire
    '{3'b000, 1'b0, 5'd0, 2'd0, 1'b1, 5'd1, 3'b001, 1'b1, 5'd3, 8'd4},  // R4 unused lanes
    '{3'b000, 1'b1, 5'd5, 2'd0, 1'b0, 5'd2, 3'b000, 1'b1, 5'd3, 8'd6},  // R6
    '{3'b000, 1'b1, 5'd2, 2'd1, 1'b0, 5'd2, 3'b000, 1'b1, 5'd3, 8'd8},  // R8 line5 ignored
    '{3'b000, 1'b0, 5'd0, 2'd0, 1'b1, 5'd2, 3'b010, 1'b1, 5'd3, 8'd7},  // R7
    '{3'b000, 1'b0, 5'd0, 2'd0, 1'b0, 5'd3, 3'b000, 1'b1, 5'd3, 8'd6},  // R6
    '{3'b000, 1'b0, 5'd0, 2'd0, 1'b0, 5'd3, 3'b000, 1'b1, 5'd3, 8'd10}, // R10 zero mask row next
    '{3'b000, 1'b0, 5'd0, 2'd0, 1'b0, 5'd3, 3'b000, 1'b1, 5'd3, 8'd10}  // R10
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    string rq;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // table walk (rows 11-12 check zero-mask request from row 11 had no effect)
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      rq = $sformatf("R%0d", VEC[i].req);
      chk(rv == VEC[i].erv, rq, int'(rv), int'(VEC[i].erv));
      chk(rline == VEC[i].erl, rq, int'(rline), int'(VEC[i].erl));
      chk(ardy == VEC[i].erdy, rq, int'(ardy), int'(VEC[i].erdy));
      chk(aline == VEC[i].eal, rq, int'(aline), int'(VEC[i].eal));
      if (VEC[i].erv) chk(rmask == VEC[i].emask, "R7", int'(rmask), int'(VEC[i].emask));
      amask = VEC[i].am;
      atag  = {8'(i + 2), 8'(i + 1), 8'(i)};
      cv    = VEC[i].cv;
      cline = VEC[i].cl;
      clane = VEC[i].cn;
    end

    // flush before the fill test
    @(negedge clk); idle(); flush = 1'b1;
    @(negedge clk); idle();
    chk(aline == 0 && rline == 0 && ardy && !rv, "R11", int'(aline), 0);

    // fill all lines, single lane each
    for (int i = 0; i < 24; i++) begin
      if (i > 0) @(negedge clk);
      chk(aline == 5'(i), "R2", int'(aline), i);
      chk(ardy, "R2", int'(ardy), 1);
      amask = 3'b001;
      atag  = {16'h0, 8'(8'h40 + i)};
    end
    @(negedge clk); idle();
    chk(!ardy, "R3", int'(ardy), 0);
    chk(aline == 0, "R2", int'(aline), 0);
    amask = 3'b111; atag = '1;
    @(negedge clk); idle();
    chk(!ardy, "R3", int'(ardy), 0);
    chk(aline == 0, "R3", int'(aline), 0);
    chk(!rv, "R4", int'(rv), 0);
    cv = 1'b1; cline = 5'd0; clane = 2'd0;
    @(negedge clk); idle();
    chk(rv && rline == 0, "R6", int'(rv), 1);
    chk(rtag[7:0] == 8'h40, "R7", int'(rtag[7:0]), 'h40);
    chk(rtag[23:8] == 16'h0, "R3", int'(rtag[23:8]), 0);
    @(negedge clk);
    chk(ardy && rline == 1 && !rv, "R6", int'(rline), 1);

    // complete lines 23..1 in reverse: head blocks everything until line 1 completes
    for (int i = 23; i >= 1; i--) begin
      cv = 1'b1; cline = 5'(i); clane = 2'd0;
      @(negedge clk);
      if (i > 1) chk(!rv, "R5", int'(rv), 0);
    end
    idle();
    for (int i = 1; i < 24; i++) begin
      chk(rv && rline == 5'(i), "R6", int'(rline), i);
      chk(rtag[7:0] == 8'(8'h40 + i), "R7", int'(rtag[7:0]), 'h40 + i);
      @(negedge clk);
    end
    chk(!rv && rline == 0, "R6", int'(rline), 0);

    // flush drops partial lines
    amask = 3'b111; atag = 24'h030201;
    @(negedge clk); amask = 3'b011;
    @(negedge clk); idle(); cv = 1'b1; cline = 5'd1; clane = 2'd0;
    @(negedge clk); idle(); flush = 1'b1; cv = 1'b1; cline = 5'd1; clane = 2'd1;
    @(negedge clk); idle();
    chk(!rv && ardy && aline == 0 && rline == 0, "R11", int'(aline), 0);
    amask = 3'b100; atag = 24'hAA0000;
    @(negedge clk); idle();
    chk(!rv, "R11", int'(rv), 0);
    cv = 1'b1; cline = 5'd0; clane = 2'd2;
    @(negedge clk); idle();
    chk(rv && rmask == 3'b100 && rline == 0, "R7", int'(rmask), 4);
    chk(rtag[23:16] == 8'hAA, "R7", int'(rtag[23:16]), 'hAA);
    @(negedge clk);
    chk(!rv && rline == 1 && aline == 1, "R6", int'(rline), 1);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule